// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Slave

This block sits between a host that shares one set of pins for address and data and an internal register file. A run-time strap input picks how the strobe pins are read. With the strap high, a positive data-strobe pulse frames the data phase and a separate direction line tells reads from writes. With the strap low, the data-strobe pin behaves like a memory output enable for reads, and the direction line becomes an active-low write strobe.

Every host input, including the shared bus, is sampled by a faster internal clock through a synchronizer chain, and all edges are found in that domain. The address is taken from the shared bus when the address strobe falls while the chip is selected. A read opens a window during which the block drives the bus; its data comes from the register file one cycle after a single-cycle read request. A write ends in one single-cycle write request that carries the latched address and the captured data. An external block-access input locks the host out.

The tri-state pad itself is outside the block. The block only gives the value to drive and an output-enable.

Top module: `mbus_slave`

## Requirements
- R1: After reset, rd_req, wr_req and bus_oe are 0 and req_addr is 0.
- R2: The address is taken from bus_in on a falling edge of addr_stb only while sel_n is low. An addr_stb pulse while sel_n is high leaves req_addr unchanged.
- R3: With mode_sel=1, data_stb high together with dir high opens a read window. The window raises rd_req once, with req_addr equal to the latched address. While the window is open, bus_oe is 1 and bus_out equals the register-file data for that address.
- R4: With mode_sel=1, a falling edge of data_stb while dir is low raises wr_req once. The request carries the bus value present while data_stb was high.
- R5: With mode_sel=0, data_stb low opens a read window with the same request, output-enable and data behaviour as in R3. With mode_sel=0, dir has no read meaning.
- R6: With mode_sel=0, a low pulse on dir raises wr_req once, on its rising edge. The request carries the bus value present while dir was low.
- R7: bus_oe is never 1 while sel_n is high or lock is high, and it drops when the read window closes.
- R8: While lock is high, no read or write request is issued and bus_oe stays 0.
- R9: rd_req and wr_req each last exactly one cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Strap: 1 = data strobe with direction line, 0 = output-enable style |
| sel_n | input | 1 | Active-low chip select |
| addr_stb | input | 1 | Address strobe; address taken on its falling edge |
| data_stb | input | 1 | Data strobe (mode 1) or active-low read enable (mode 0) |
| dir | input | 1 | Read-high/write-low (mode 1) or active-low write strobe (mode 0) |
| lock | input | 1 | Blocks all host access while high |
| bus_in | input | BUS_W | Value seen on the shared address/data pins |
| bus_out | output | BUS_W | Read data to drive onto the shared pins |
| bus_oe | output | 1 | Drive enable for the shared pins |
| rd_req | output | 1 | One-cycle read request to the register file |
| wr_req | output | 1 | One-cycle write request to the register file |
| req_addr | output | BUS_W | Latched address for both request types |
| wr_data | output | BUS_W | Write data accompanying wr_req |
| rd_data | input | BUS_W | Register-file data, sampled the cycle after rd_req |

## Verification
Reads and writes run in both strap settings on different addresses and data values, so the bench can tell whether the pin meanings really swap with the strap. A data value carried under the wrong address, or a missing transfer, shows up in the scoreboard. An address-strobe pulse with the chip deselected, and a strobe burst with the chip deselected, separate a correct select gate from one that is missing. Strobes while lock is high check that no request is made and that the bus is never driven.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef struct packed {
      logic mode;
      logic cs_n;
      logic as;
      logic ds;
      logic rw;
      logic blk;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
   localparam ctl_t CTL_IDLE = '{mode: 1'b0, cs_n: 1'b1, as: 1'b0,
                                 ds: 1'b0, rw: 1'b1, blk: 1'b0};
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
   import mbus_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctl_t             cur,
   input  logic [BUS_W-1:0] cur_ad,
   output logic [BUS_W-1:0] addr_q,
   output logic [BUS_W-1:0] wdata_q,
   output logic             rd_req_q,
   output logic             wr_req_q,
   output logic             rd_win_q
);
   ctl_t             prv;
   logic [BUS_W-1:0] prv_ad;
   logic             access_ok;
   logic             as_fall;
   logic             rd_win;
   logic             wr_evt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         prv    <= CTL_IDLE;
         prv_ad <= '0;
      end else begin
         prv    <= cur;
         prv_ad <= cur_ad;
      end

   always_comb begin
      access_ok = !cur.cs_n && !cur.blk;
      as_fall   = prv.as && !cur.as && !cur.cs_n;
      if (cur.mode) begin
         rd_win = access_ok && cur.ds && cur.rw;
         wr_evt = access_ok && prv.ds && !cur.ds && !cur.rw;
      end else begin
         rd_win = access_ok && !cur.ds;
         wr_evt = access_ok && !prv.rw && cur.rw;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         rd_req_q <= 1'b0;
         wr_req_q <= 1'b0;
         rd_win_q <= 1'b0;
      end else begin
         if (as_fall) addr_q <= prv_ad;
         if (wr_evt) wdata_q <= prv_ad;
         rd_req_q <= rd_win && !rd_win_q;
         wr_req_q <= wr_evt;
         rd_win_q <= rd_win;
      end
endmodule

// File: rtl/mbus_rdpath.sv
module mbus_rdpath #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             rd_win,
   input  logic             cs_n_raw,
   input  logic             blk_raw,
   input  logic [BUS_W-1:0] rd_data,
   output logic [BUS_W-1:0] dout,
   output logic             oe
);
   logic rd_pend;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rd_pend <= 1'b0;
         dout    <= '0;
      end else begin
         rd_pend <= rd_req;
         if (rd_pend) dout <= rd_data;
      end

   assign oe = rd_win && !cs_n_raw && !blk_raw;
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
   import mbus_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sel,
   input  logic             sel_n,
   input  logic             addr_stb,
   input  logic             data_stb,
   input  logic             dir,
   input  logic             lock,
   input  logic [BUS_W-1:0] bus_in,
   output logic [BUS_W-1:0] bus_out,
   output logic             bus_oe,
   output logic             rd_req,
   output logic             wr_req,
   output logic [BUS_W-1:0] req_addr,
   output logic [BUS_W-1:0] wr_data,
   input  logic [BUS_W-1:0] rd_data
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbus_slave: SYNC_STAGES must be at least 2");
      end
      if (BUS_W < 1) begin : g_bad_width
         $error("mbus_slave: BUS_W must be positive");
      end
   endgenerate

   ctl_t             raw_ctl;
   ctl_t             s_ctl;
   logic [BUS_W-1:0] s_ad;
   logic             win;

   assign raw_ctl = '{mode: mode_sel, cs_n: sel_n, as: addr_stb,
                      ds: data_stb, rw: dir, blk: lock};

   mbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(s_ctl)
   );

   mbus_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(s_ad)
   );

   mbus_decode #(.BUS_W(BUS_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cur(s_ctl), .cur_ad(s_ad),
      .addr_q(req_addr), .wdata_q(wr_data),
      .rd_req_q(rd_req), .wr_req_q(wr_req), .rd_win_q(win)
   );

   mbus_rdpath #(.BUS_W(BUS_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_win(win),
      .cs_n_raw(sel_n), .blk_raw(lock), .rd_data(rd_data),
      .dout(bus_out), .oe(bus_oe)
   );
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic sel_n,
   input logic lock,
   input logic bus_oe,
   input logic rd_req,
   input logic wr_req
);
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req); // R9
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !wr_req); // R9
   AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req)); // R9
   AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !sel_n && !lock); // R7
   AST_LOCK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lock, 3) && $past(lock, 2) && $past(lock, 1) && lock) |-> !rd_req && !wr_req); // R8
endmodule

bind mbus_slave mbus_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .lock(lock),
   .bus_oe(bus_oe), .rd_req(rd_req), .wr_req(wr_req)
);

// File: tb/mbus_slave_test.sv
module mbus_slave_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_sel = 1'b1, sel_n = 1'b1, addr_stb = 1'b0;
   logic         data_stb = 1'b0, dir = 1'b1, lock = 1'b0;
   logic [W-1:0] bus_in = '0;
   logic [W-1:0] bus_out, req_addr, wr_data, rd_data;
   logic         bus_oe, rd_req, wr_req;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit           is_wr;
      logic [W-1:0] addr;
      logic [W-1:0] data;
   } item_t;
   item_t exp_q[$];

   always #2 clk = ~clk;

   function automatic logic [W-1:0] regval(logic [W-1:0] a);
      return a ^ 8'hA5;
   endfunction

   assign rd_data = regval(req_addr);

   mbus_slave uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sel_n(sel_n),
      .addr_stb(addr_stb), .data_stb(data_stb), .dir(dir), .lock(lock),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on every request
   always @(negedge clk) begin
      if (rst_n && (rd_req || wr_req)) begin
         item_t it;
         chk("R9 single request", {31'd0, rd_req && wr_req}, 32'd0);
         if (exp_q.size() == 0) begin
            chk("R8 unexpected request", 32'd1, 32'd0);
         end else begin
            it = exp_q.pop_front();
            chk(it.is_wr ? "R4/R6 request kind" : "R3/R5 request kind",
                {31'd0, wr_req}, {31'd0, it.is_wr});
            chk("R2 request address", {24'd0, req_addr}, {24'd0, it.addr});
            if (it.is_wr)
               chk("R4/R6 write data", {24'd0, wr_data}, {24'd0, it.data});
         end
      end
   end

   task automatic addr_phase(logic [W-1:0] a);
      bus_in = a; addr_stb = 1'b1; tick(3);
      addr_stb = 1'b0; tick(3);
   endtask

   task automatic push(bit w, logic [W-1:0] a, logic [W-1:0] d);
      item_t it;
      it.is_wr = w; it.addr = a; it.data = d;
      exp_q.push_back(it);
   endtask

   task automatic strobe_write(logic [W-1:0] a, logic [W-1:0] d, bit expect_req);
      addr_phase(a);
      if (expect_req) push(1'b1, a, d);
      bus_in = d; dir = 1'b0; tick(2);
      data_stb = 1'b1; tick(4);
      data_stb = 1'b0; tick(3);
      bus_in = 8'hEE; dir = 1'b1; tick(4);
   endtask

   task automatic strobe_read(logic [W-1:0] a, bit do_addr, bit expect_req, string tag);
      if (do_addr) addr_phase(a);
      if (expect_req) push(1'b0, a, '0);
      dir = 1'b1; data_stb = 1'b1; tick(7);
      chk({tag, " bus_oe in window"}, {31'd0, bus_oe}, {31'd0, expect_req});
      if (expect_req) chk({tag, " read data"}, {24'd0, bus_out}, {24'd0, regval(a)});
      data_stb = 1'b0; tick(5);
      chk("R7 bus_oe after window", {31'd0, bus_oe}, 32'd0);
   endtask

   task automatic oe_read(logic [W-1:0] a);
      addr_phase(a);
      push(1'b0, a, '0);
      data_stb = 1'b0; tick(7);
      chk("R5 bus_oe in window", {31'd0, bus_oe}, 32'd1);
      chk("R5 read data", {24'd0, bus_out}, {24'd0, regval(a)});
      data_stb = 1'b1; tick(5);
      chk("R7 bus_oe after window", {31'd0, bus_oe}, 32'd0);
   endtask

   task automatic oe_write(logic [W-1:0] a, logic [W-1:0] d);
      addr_phase(a);
      push(1'b1, a, d);
      bus_in = d; tick(2);
      dir = 1'b0; tick(4);
      dir = 1'b1; tick(3);
      bus_in = 8'h11; tick(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
      chk("R1 wr_req", {31'd0, wr_req}, 32'd0);
      chk("R1 bus_oe", {31'd0, bus_oe}, 32'd0);
      chk("R1 req_addr", {24'd0, req_addr}, 32'd0);

      // strobe mode (mode_sel=1)
      sel_n = 1'b0; tick(4);
      strobe_write(8'h12, 8'h3C, 1'b1);            // R4
      strobe_write(8'hF0, 8'h81, 1'b1);            // R4
      strobe_read(8'h12, 1'b1, 1'b1, "R3");        // R3
      strobe_read(8'h7E, 1'b1, 1'b1, "R3");        // R3

      // R2: address pulse while deselected is ignored
      sel_n = 1'b1; tick(3);
      addr_phase(8'h99);
      sel_n = 1'b0; tick(4);
      chk("R2 address unchanged", {24'd0, req_addr}, 32'h7E);
      strobe_read(8'h7E, 1'b0, 1'b1, "R2");

      // R7: strobes while deselected drive nothing
      sel_n = 1'b1; tick(3);
      strobe_read(8'h7E, 1'b0, 1'b0, "R7");

      // R8: lock blocks everything
      sel_n = 1'b0; lock = 1'b1; tick(4);
      strobe_write(8'h44, 8'h55, 1'b0);
      strobe_read(8'h44, 1'b0, 1'b0, "R8");
      lock = 1'b0; tick(4);

      // switch strap while deselected, then output-enable style
      sel_n = 1'b1; tick(2);
      mode_sel = 1'b0; data_stb = 1'b1; dir = 1'b1; tick(5);
      sel_n = 1'b0; tick(4);
      oe_write(8'h21, 8'hC3);                      // R6
      oe_write(8'h00, 8'hFF);                      // R6
      oe_read(8'h21);                              // R5
      oe_read(8'hB4);                              // R5

      // back to strobe mode
      sel_n = 1'b1; tick(2);
      mode_sel = 1'b1; data_stb = 1'b0; dir = 1'b1; tick(5);
      sel_n = 1'b0; tick(4);
      strobe_write(8'h5A, 8'h0F, 1'b1);            // R4
      tick(10);
      chk("R9 scoreboard drained", exp_q.size(), 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule